// File: doc/BRIEF.md
# PHY Management Register File

This block is the register bank behind the management port of an Ethernet PHY. It holds thirty-two 16-bit words and is reached through a plain parallel port: a 5-bit word address, write data with a write strobe, and a read strobe with combinational read data. A serial management front end, which is not part of this block, turns its frames into single-cycle strobes on this port.

Configuration pins are captured while the hardware reset is held. They appear in a read-only strap word and also seed the reset defaults of the control word. Live conditions from the PHY core feed the status word through bits that stick until read. Some stick high on their event (jabber, remote fault). The link bit sticks low when the link drops.

Change events from the core collect in an interrupt pending word. That word drives an interrupt output through a global enable bit. The pending word is emptied by reading it or by a self-clearing clear command. An indirect window gives access to a 64-word internal memory through a pointer that advances after every data access. A soft-reset bit in the control word reloads the bank to its strap-based defaults.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The 12-bit strap input is captured while rst_n is low. Word 0x10 reads it with bit 11 auto-neg enable, bit 10 full duplex, bit 9 speed high, bit 8 speed low, bit 7 MAC clock enable, bit 6 auto crossover enable, bit 5 multi-node, and bits 4:0 PHY address. Strap changes after reset do not affect it.
- R2: After reset, control word 0x00 reads speed low at bit 13, auto-neg enable at bit 12, full duplex at bit 8 and speed high at bit 6, all from the captured straps. Every other bit reads 0.
- R3: A write to 0x00 stores bits 14,13,12,11,10,8,6 and is visible from the cycle after the strobe. Bits 7 and 5:0 always read 0.
- R4: Writing 1 to bit 15 of 0x00 makes that bit read 1 for exactly one cycle. On the following cycle the control word is back to its strap defaults, and the interrupt mask, interrupt pending word and memory pointer are 0.
- R5: Writing 1 to bit 9 of 0x00 (restart auto-neg) makes it read 1 for one cycle; it then reads 0.
- R6: Status word 0x01 always reads 1 in bits 8, 6, 3 and 0. Bit 5 follows the live auto-neg-done input.
- R7: Status bit 1 (jabber) and bit 4 (remote fault) go to 1 when their input is 1 and stay 1 until 0x01 is read; after the read they show the live input again.
- R8: Status bit 2 (link) goes to 0 when link_up_i is 0 and stays 0 until 0x01 is read; after the read it shows the live input again.
- R9: Each int_ev_i bit sets the same bit of pending word 0x14 (bit 0 speed, 1 link, 2 duplex, 3 crossover, 4 polarity, 5 jabber, 6 next page, 7 auto-neg done, 8 remote fault). A read of 0x14 returns the pending bits and clears them. An event in the cycle of that read stays pending.
- R10: irq_o is 1 exactly when some pending bit is set and bit 15 of mask word 0x15 is 1.
- R11: Writing 1 to bit 15 of 0x17 empties the pending word. Word 0x17 always reads 0.
- R12: Word 0x1D reads and writes a 64-word memory indexed by the low 6 bits of pointer word 0x1E. Each read or write of 0x1D adds 1 to the full 16-bit pointer.
- R13: Writes to read-only words (0x01, 0x10, 0x14) and to unmapped words have no effect. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset; straps are captured while low |
| reg_addr_i | input | 5 | Word address |
| reg_wdata_i | input | 16 | Write data |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe; triggers read side effects |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| strap_i | input | 12 | Configuration pins |
| link_up_i | input | 1 | Live link state |
| jabber_i | input | 1 | Live jabber condition |
| rfault_i | input | 1 | Live remote fault condition |
| an_done_i | input | 1 | Live auto-negotiation complete |
| int_ev_i | input | 9 | Single-cycle change event pulses |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The sticky status bits are tried three ways: with a one-cycle event followed by a read, with a peek that has no read strobe, and with a second read. This shows a latch that holds until read apart from one that clears on any access or never clears. The interrupt path is driven with several event patterns: two bits at once, an event landing in the same cycle as a pending read, a masked state, and a clear command. This separates event capture, read clearing, masking and the clear command. The memory window is tried with consecutive writes, read-back and a pointer at the 63-to-64 boundary, which shows whether the pointer advances in full width while the index wraps. Soft reset and restart are sampled cycle by cycle to pin down the one-cycle pulse.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW      = 16;
  localparam int AW      = 5;
  localparam int STRAP_W = 12;
  localparam int N_EV    = 9;

  localparam logic [AW-1:0] A_CTRL  = 5'h00;
  localparam logic [AW-1:0] A_STAT  = 5'h01;
  localparam logic [AW-1:0] A_STRAP = 5'h10;
  localparam logic [AW-1:0] A_ISTAT = 5'h14;
  localparam logic [AW-1:0] A_IMASK = 5'h15;
  localparam logic [AW-1:0] A_ICLR  = 5'h17;
  localparam logic [AW-1:0] A_XDATA = 5'h1D;
  localparam logic [AW-1:0] A_XPTR  = 5'h1E;

  // control bits that hold their written value (15 and 9 are one-shot)
  localparam logic [DW-1:0] CTRL_KEEP  = 16'h7D40;
  // capability bits of the status word that are tied to 1
  localparam logic [DW-1:0] STAT_FIXED = 16'h0149;

  typedef struct packed {
    logic       an_en;
    logic       fdx;
    logic       spd_hi;
    logic       spd_lo;
    logic       macclk;
    logic       xover;
    logic       multi;
    logic [4:0] phyad;
  } strap_t;

  function automatic logic [DW-1:0] ctrl_defaults(strap_t s);
    logic [DW-1:0] r;
    r     = '0;
    r[13] = s.spd_lo;
    r[12] = s.an_en;
    r[8]  = s.fdx;
    r[6]  = s.spd_hi;
    return r;
  endfunction

  function automatic logic [DW-1:0] stat_word(logic rf, logic an, logic lnk, logic jab);
    logic [DW-1:0] r;
    r    = STAT_FIXED;
    r[5] = an;
    r[4] = rf;
    r[2] = lnk;
    r[1] = jab;
    return r;
  endfunction
endpackage

// File: rtl/phy_mgmt_sticky.sv
module phy_mgmt_sticky #(
  parameter logic ACTIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic live_i,
  input  logic rd_i,
  output logic bit_o
);
  logic stk_q;
  logic hit;

  assign hit = (live_i == ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) stk_q <= 1'b0;
    else if (hit)        stk_q <= 1'b1;
    else if (rd_i)       stk_q <= 1'b0;
  end

  assign bit_o = stk_q ? ACTIVE : live_i;

  // R7 R8: an event is still visible on the next cycle whatever the live input does
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr_i) |=> (bit_o == ACTIVE));
endmodule

// File: rtl/phy_mgmt_irq.sv
module phy_mgmt_irq #(
  parameter int N_EV = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [N_EV-1:0] ev_i,
  input  logic            rd_clr_i,
  input  logic            wipe_i,
  input  logic            mask_we_i,
  input  logic            mask_d_i,
  output logic [N_EV-1:0] pend_o,
  output logic            mask_o,
  output logic            irq_o
);
  logic [N_EV-1:0] pend_q;
  logic            mask_q;
  logic            drop;

  assign drop = rd_clr_i || wipe_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) pend_q <= '0;
    else                 pend_q <= (drop ? '0 : pend_q) | ev_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) mask_q <= 1'b0;
    else if (mask_we_i)  mask_q <= mask_d_i;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = mask_q && (pend_q != '0);

  // R9
  ev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_i != '0) && !clr_i) |=> ((pend_o & $past(ev_i)) == $past(ev_i)));
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_o |-> !irq_o);
  // R11
  wipe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i && (ev_i == '0)) |=> (pend_o == '0));
endmodule

// File: rtl/phy_mgmt_xmem.sv
module phy_mgmt_xmem #(
  parameter int DEPTH = 64,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          acc_rd_i,
  input  logic          acc_wr_i,
  input  logic          ptr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] data_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ptr_q;
  logic [IW-1:0] idx;
  logic          step;

  assign idx  = ptr_q[IW-1:0];
  assign step = acc_rd_i || acc_wr_i;

  always_ff @(posedge clk) begin
    if (acc_wr_i) mem[idx] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) ptr_q <= '0;
    else if (ptr_we_i)   ptr_q <= wdata_i;
    else if (step)       ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o  = ptr_q;
  assign data_o = mem[idx];

  // R12
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ptr_we_i && !clr_i) |=> (ptr_o == $past(ptr_o) + 16'd1));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int XMEM_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               link_up_i,
  input  logic               jabber_i,
  input  logic               rfault_i,
  input  logic               an_done_i,
  input  logic [N_EV-1:0]    int_ev_i,
  output logic               irq_o
);
  strap_t        strap_q;
  logic [DW-1:0] ctrl_q;
  logic          srst_q;
  logic          an_rs_q;

  // named access events
  logic wr_ctrl, wr_mask, wr_clr, wr_ptr, wr_xdata;
  logic rd_stat, rd_istat, rd_xdata;
  logic sw_clr;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_mask  = reg_wr_i && (reg_addr_i == A_IMASK);
  assign wr_clr   = reg_wr_i && (reg_addr_i == A_ICLR) && reg_wdata_i[15];
  assign wr_ptr   = reg_wr_i && (reg_addr_i == A_XPTR);
  assign wr_xdata = reg_wr_i && (reg_addr_i == A_XDATA);
  assign rd_stat  = reg_rd_i && (reg_addr_i == A_STAT);
  assign rd_istat = reg_rd_i && (reg_addr_i == A_ISTAT);
  assign rd_xdata = reg_rd_i && (reg_addr_i == A_XDATA);
  assign sw_clr   = srst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_t'(strap_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_defaults(strap_t'(strap_i));
      srst_q  <= 1'b0;
      an_rs_q <= 1'b0;
    end else if (srst_q) begin
      ctrl_q  <= ctrl_defaults(strap_q);
      srst_q  <= 1'b0;
      an_rs_q <= 1'b0;
    end else begin
      srst_q  <= wr_ctrl && reg_wdata_i[15];
      an_rs_q <= wr_ctrl && reg_wdata_i[9];
      if (wr_ctrl) ctrl_q <= reg_wdata_i & CTRL_KEEP;
    end
  end

  // sticky status bits: index 0 jabber, 1 remote fault (latch high)
  logic [1:0] lh_live, lh_bit;
  logic       link_bit;
  assign lh_live = {rfault_i, jabber_i};

  for (genvar g = 0; g < 2; g++) begin : g_lh
    phy_mgmt_sticky #(.ACTIVE(1'b1)) u_lh (
      .clk(clk), .rst_n(rst_n), .clr_i(sw_clr),
      .live_i(lh_live[g]), .rd_i(rd_stat), .bit_o(lh_bit[g]));
  end

  phy_mgmt_sticky #(.ACTIVE(1'b0)) u_link (
    .clk(clk), .rst_n(rst_n), .clr_i(sw_clr),
    .live_i(link_up_i), .rd_i(rd_stat), .bit_o(link_bit));

  logic [N_EV-1:0] pend;
  logic            mask_en;

  phy_mgmt_irq #(.N_EV(N_EV)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr_i(sw_clr), .ev_i(int_ev_i),
    .rd_clr_i(rd_istat), .wipe_i(wr_clr), .mask_we_i(wr_mask),
    .mask_d_i(reg_wdata_i[15]), .pend_o(pend), .mask_o(mask_en), .irq_o(irq_o));

  logic [DW-1:0] xptr, xdata;

  phy_mgmt_xmem #(.DEPTH(XMEM_DEPTH), .DW(DW)) u_xmem (
    .clk(clk), .rst_n(rst_n), .clr_i(sw_clr), .acc_rd_i(rd_xdata),
    .acc_wr_i(wr_xdata), .ptr_we_i(wr_ptr), .wdata_i(reg_wdata_i),
    .ptr_o(xptr), .data_o(xdata));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q | {srst_q, 5'b0, an_rs_q, 9'b0};
      A_STAT:  reg_rdata_o = stat_word(lh_bit[1], an_done_i, link_bit, lh_bit[0]);
      A_STRAP: reg_rdata_o = {{(DW-STRAP_W){1'b0}}, strap_q};
      A_ISTAT: reg_rdata_o = {{(DW-N_EV){1'b0}}, pend};
      A_IMASK: reg_rdata_o = {mask_en, {(DW-1){1'b0}}};
      A_XDATA: reg_rdata_o = xdata;
      A_XPTR:  reg_rdata_o = xptr;
      default: reg_rdata_o = '0;
    endcase
  end

  // R4
  soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  // R5
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_rs_q |=> !an_rs_q);
endmodule

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic [11:0] strap = 12'hA5B;
  logic        link = 1'b1, jab = 1'b0, rf = 1'b0, an_done = 1'b1;
  logic [8:0]  ev = '0;
  logic        irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_rdata_o(rdata), .strap_i(strap),
    .link_up_i(link), .jabber_i(jab), .rfault_i(rf), .an_done_i(an_done),
    .int_ev_i(ev), .irq_o(irq));

  // bench restatement of the control defaults (R2)
  function automatic logic [15:0] exp_ctrl(logic [11:0] s);
    return (16'(s[8]) << 13) | (16'(s[11]) << 12) | (16'(s[10]) << 8) | (16'(s[9]) << 6);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse_ev(logic [8:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_strap_defaults();
    logic [15:0] v;
    strap = 12'h000;
    peek(5'h10, v); chk("R1 strap word", v, 16'h0A5B);
    peek(5'h00, v); chk("R2 control defaults", v, exp_ctrl(12'hA5B));
    peek(5'h0C, v); chk("R13 unmapped reads 0", v, 16'h0000);
  endtask

  task automatic t_ctrl_write();
    logic [15:0] v;
    wr_reg(5'h00, 16'h7FFF);
    #1 chk("R3 control write", rdata, 16'h7F40);
    @(negedge clk); #1 chk("R5 restart clears", rdata, 16'h7D40);
    wr_reg(5'h00, 16'h4100);
    peek(5'h00, v); chk("R3 control rewrite", v, 16'h4100);
  endtask

  task automatic t_ro_writes();
    logic [15:0] v;
    wr_reg(5'h10, 16'h0000);
    peek(5'h10, v); chk("R13 strap write ignored", v, 16'h0A5B);
    wr_reg(5'h0B, 16'hFFFF);
    peek(5'h0B, v); chk("R13 reserved write ignored", v, 16'h0000);
    wr_reg(5'h01, 16'h0000);
    peek(5'h01, v); chk("R13 status write ignored", v, 16'h016D);
    wr_reg(5'h14, 16'h01FF);
    peek(5'h14, v); chk("R13 pending write ignored", v, 16'h0000);
  endtask

  task automatic t_status();
    logic [15:0] v;
    peek(5'h01, v); chk("R6 status fixed bits", v, 16'h016D);
    an_done = 1'b0;
    peek(5'h01, v); chk("R6 live an done", v, 16'h014D);
    an_done = 1'b1;
    // R7 jabber latch high
    @(negedge clk); jab = 1'b1; @(negedge clk); jab = 1'b0;
    peek(5'h01, v); chk("R7 jabber held", v, 16'h016F);
    rd_reg(5'h01, v); chk("R7 jabber read", v, 16'h016F);
    peek(5'h01, v); chk("R7 jabber after read", v, 16'h016D);
    @(negedge clk); rf = 1'b1; @(negedge clk); rf = 1'b0;
    peek(5'h01, v); chk("R7 remote fault held", v, 16'h017D);
    rd_reg(5'h01, v);
    peek(5'h01, v); chk("R7 remote fault after read", v, 16'h016D);
    // R8 link latch low
    @(negedge clk); link = 1'b0; @(negedge clk); link = 1'b1;
    peek(5'h01, v); chk("R8 link held low", v, 16'h0169);
    rd_reg(5'h01, v); chk("R8 link read", v, 16'h0169);
    peek(5'h01, v); chk("R8 link after read", v, 16'h016D);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    chk("R10 irq idle", {15'b0, irq}, 16'h0000);
    pulse_ev(9'h022);
    peek(5'h14, v); chk("R9 pending capture", v, 16'h0022);
    chk("R10 irq masked", {15'b0, irq}, 16'h0000);
    wr_reg(5'h15, 16'h8000);
    peek(5'h15, v); chk("R10 mask readback", v, 16'h8000);
    chk("R10 irq raised", {15'b0, irq}, 16'h0001);
    rd_reg(5'h14, v); chk("R9 pending read", v, 16'h0022);
    peek(5'h14, v); chk("R9 cleared by read", v, 16'h0000);
    chk("R10 irq dropped", {15'b0, irq}, 16'h0000);
    pulse_ev(9'h008);
    @(negedge clk); addr = 5'h14; rd = 1'b1; ev = 9'h001; #1 v = rdata;
    @(negedge clk); rd = 1'b0; ev = '0;
    chk("R9 read during event", v, 16'h0008);
    peek(5'h14, v); chk("R9 event kept", v, 16'h0001);
    pulse_ev(9'h180);
    wr_reg(5'h17, 16'h8000);
    peek(5'h14, v); chk("R11 wiped", v, 16'h0000);
    peek(5'h17, v); chk("R11 clear reads 0", v, 16'h0000);
    chk("R10 irq after wipe", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_xmem();
    logic [15:0] v;
    wr_reg(5'h1E, 16'h0005);
    wr_reg(5'h1D, 16'hBEEF);
    wr_reg(5'h1D, 16'h1234);
    peek(5'h1E, v); chk("R12 pointer after writes", v, 16'h0007);
    wr_reg(5'h1E, 16'h0005);
    rd_reg(5'h1D, v); chk("R12 data word 5", v, 16'hBEEF);
    rd_reg(5'h1D, v); chk("R12 data word 6", v, 16'h1234);
    peek(5'h1E, v); chk("R12 pointer after reads", v, 16'h0007);
    wr_reg(5'h1E, 16'h003F);
    wr_reg(5'h1D, 16'hAAAA);
    wr_reg(5'h1D, 16'h5555);
    peek(5'h1E, v); chk("R12 pointer full width", v, 16'h0041);
    wr_reg(5'h1E, 16'h0000);
    rd_reg(5'h1D, v); chk("R12 index wraps", v, 16'h5555);
    wr_reg(5'h1E, 16'h003F);
    peek(5'h1D, v); chk("R12 top word", v, 16'hAAAA);
  endtask

  task automatic t_soft_reset();
    logic [15:0] v;
    wr_reg(5'h00, 16'h4100);
    wr_reg(5'h15, 16'h8000);
    pulse_ev(9'h004);
    wr_reg(5'h1E, 16'h0010);
    wr_reg(5'h00, 16'h8000);
    addr = 5'h00; #1 chk("R4 reset bit reads 1", rdata, 16'h8000);
    @(negedge clk); #1 chk("R4 control reloaded", rdata, exp_ctrl(12'hA5B));
    peek(5'h15, v); chk("R4 mask cleared", v, 16'h0000);
    peek(5'h14, v); chk("R4 pending cleared", v, 16'h0000);
    peek(5'h1E, v); chk("R4 pointer cleared", v, 16'h0000);
    peek(5'h10, v); chk("R1 strap kept over soft reset", v, 16'h0A5B);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_strap_defaults();
    t_ctrl_write();
    t_ro_writes();
    t_status();
    t_irq();
    t_xmem();
    t_soft_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule